// File: doc/BRIEF.md
# Quadrature Early/Late Phase Detector

This block is the digital decision stage of a clock and data recovery loop. Each valid cycle it receives a word of `LANES` consecutive bit periods. Each bit period brings three samples: the data sample taken on the rising edge of the in-phase clock, the transition sample taken on the falling edge of the in-phase clock just before it, and a sample taken by a quadrature clock. When the loop is locked, the data transitions fall on the falling edge of the in-phase clock. The rising-edge sample therefore serves as the retimed data.

For every bit period that holds a data transition, the block compares the transition sample with the bits on either side of it. It then raises a late (up) or an early (down) correction pulse for that lane. When input jitter exceeds a quarter unit interval, the quadrature sample stops agreeing with the adjacent data sample. In that case the block also raises a boost pulse in the same direction, which asks the charge pump for a larger correction. All pulses and the retimed word come from registers, one cycle after the valid input cycle.

Top module: `qbb_phase_det`

## Requirements
- R1: While rst_ni is low and until the first valid word, valid_o, data_o, up_o, dn_o, bup_o and bdn_o are all zero.
- R2: In the cycle after a cycle with valid_i high, valid_o is 1 and data_o equals that cycle's data_i. In the cycle after a cycle with valid_i low, valid_o is 0.
- R3: For lane k (bit k is later in time than bit k-1), the previous bit is data_i[k-1]. If the previous bit differs from data_i[k] and edge_i[k] equals data_i[k], then up_o[k] is 1 in the next cycle (the clock is late).
- R4: Under the same conditions as R3, but with edge_i[k] equal to the previous bit, dn_o[k] is 1 in the next cycle (the clock is early).
- R5: A lane whose previous bit equals its current bit raises none of up_o, dn_o, bup_o or bdn_o.
- R6: bup_o[k] equals up_o[k] AND (quad_i[k] != data_i[k]). bdn_o[k] equals dn_o[k] AND (quad_i[k] != data_i[k]).
- R7: Correction outputs are pulses. All four are zero in a cycle that follows a cycle with valid_i low. up_o[k] and dn_o[k] are never both 1.
- R8: The previous bit of lane 0 is data_i[LANES-1] of the last earlier valid word. In the first valid word after reset, lane 0 raises no correction.
- R9: Cycles with valid_i low leave data_o and the stored previous bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample word valid strobe |
| data_i | input | LANES | In-phase rising-edge data samples, bit 0 earliest |
| edge_i | input | LANES | In-phase falling-edge transition samples, each taken just before the matching data bit |
| quad_i | input | LANES | Quadrature clock samples |
| valid_o | output | 1 | Retimed word valid |
| data_o | output | LANES | Retimed data word |
| up_o | output | LANES | Late correction pulses, per lane |
| dn_o | output | LANES | Early correction pulses, per lane |
| bup_o | output | LANES | Large late correction pulses |
| bdn_o | output | LANES | Large early correction pulses |

## Verification
The normal correction and the boost correction can fall in the same cycle and on the same lane. That happens whenever a lane has a transition and its quadrature sample disagrees with the data sample. The bench provokes this with a directed word whose quadrature samples are the inverse of its alternating data samples, and also through random quadrature bits. It then checks that each boost pulse matches the direction of the correction beside it and never appears without one. Lane 0 is tested across idle gaps, because its previous bit comes from the earlier word.

// File: rtl/qbb_pkg.sv
`timescale 1ns/1ps
package qbb_pkg;
  typedef struct packed {
    logic up;
    logic dn;
    logic bup;
    logic bdn;
  } corr_t;

  localparam corr_t CORR_NONE = '{up: 1'b0, dn: 1'b0, bup: 1'b0, bdn: 1'b0};
endpackage

// File: rtl/qbb_lane_dec.sv
`timescale 1ns/1ps
module qbb_lane_dec
  import qbb_pkg::*;
(
  input  logic  en_i,
  input  logic  prev_i,
  input  logic  cur_i,
  input  logic  edge_i,
  input  logic  quad_i,
  output corr_t corr_o
);
  logic trans;
  logic late;
  logic early;
  logic jitter;

  assign trans  = en_i & (prev_i ^ cur_i);
  // with a transition the edge sample matches exactly one neighbour
  assign late   = trans & (edge_i == cur_i);
  assign early  = trans & (edge_i == prev_i);
  assign jitter = quad_i ^ cur_i;

  always_comb begin
    corr_o     = CORR_NONE;
    corr_o.up  = late;
    corr_o.dn  = early;
    corr_o.bup = late & jitter;
    corr_o.bdn = early & jitter;
  end
endmodule

// File: rtl/qbb_hist.sv
`timescale 1ns/1ps
module qbb_hist (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic last_bit_i,
  output logic prev_bit_o,
  output logic prev_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_bit_o <= 1'b0;
      prev_vld_o <= 1'b0;
    end else if (valid_i) begin
      prev_bit_o <= last_bit_i;
      prev_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/qbb_out_reg.sv
`timescale 1ns/1ps
module qbb_out_reg #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LANES-1:0] data_i,
  input  logic [LANES-1:0] up_i,
  input  logic [LANES-1:0] dn_i,
  input  logic [LANES-1:0] bup_i,
  input  logic [LANES-1:0] bdn_i,
  output logic             valid_o,
  output logic [LANES-1:0] data_o,
  output logic [LANES-1:0] up_o,
  output logic [LANES-1:0] dn_o,
  output logic [LANES-1:0] bup_o,
  output logic [LANES-1:0] bdn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      up_o    <= '0;
      dn_o    <= '0;
      bup_o   <= '0;
      bdn_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= data_i;
        up_o   <= up_i;
        dn_o   <= dn_i;
        bup_o  <= bup_i;
        bdn_o  <= bdn_i;
      end else begin
        up_o  <= '0;
        dn_o  <= '0;
        bup_o <= '0;
        bdn_o <= '0;
      end
    end
  end
endmodule

// File: rtl/qbb_phase_det.sv
`timescale 1ns/1ps
module qbb_phase_det
  import qbb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LANES-1:0] data_i,
  input  logic [LANES-1:0] edge_i,
  input  logic [LANES-1:0] quad_i,
  output logic             valid_o,
  output logic [LANES-1:0] data_o,
  output logic [LANES-1:0] up_o,
  output logic [LANES-1:0] dn_o,
  output logic [LANES-1:0] bup_o,
  output logic [LANES-1:0] bdn_o
);
  localparam int LAST = LANES - 1;

  logic             prev_bit;
  logic             prev_vld;
  logic [LANES-1:0] prev_vec;
  logic [LANES-1:0] en_vec;
  logic [LANES-1:0] up_c, dn_c, bup_c, bdn_c;
  corr_t            corr [LANES];

  qbb_hist u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .last_bit_i (data_i[LAST]),
    .prev_bit_o (prev_bit),
    .prev_vld_o (prev_vld)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign prev_vec[k] = prev_bit;
      assign en_vec[k]   = prev_vld;
    end else begin : g_rest
      assign prev_vec[k] = data_i[k-1];
      assign en_vec[k]   = 1'b1;
    end

    qbb_lane_dec u_dec (
      .en_i   (en_vec[k]),
      .prev_i (prev_vec[k]),
      .cur_i  (data_i[k]),
      .edge_i (edge_i[k]),
      .quad_i (quad_i[k]),
      .corr_o (corr[k])
    );

    assign up_c[k]  = corr[k].up;
    assign dn_c[k]  = corr[k].dn;
    assign bup_c[k] = corr[k].bup;
    assign bdn_c[k] = corr[k].bdn;
  end

  qbb_out_reg #(.LANES(LANES)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .up_i    (up_c),
    .dn_i    (dn_c),
    .bup_i   (bup_c),
    .bdn_i   (bdn_c),
    .valid_o (valid_o),
    .data_o  (data_o),
    .up_o    (up_o),
    .dn_o    (dn_o),
    .bup_o   (bup_o),
    .bdn_o   (bdn_o)
  );
endmodule

// File: rtl/qbb_phase_det_chk.sv
`timescale 1ns/1ps
module qbb_phase_det_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [LANES-1:0] data_i,
  input logic [LANES-1:0] edge_i,
  input logic [LANES-1:0] quad_i,
  input logic             valid_o,
  input logic [LANES-1:0] data_o,
  input logic [LANES-1:0] up_o,
  input logic [LANES-1:0] dn_o,
  input logic [LANES-1:0] bup_o,
  input logic [LANES-1:0] bdn_o
);
  AST_DATA_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && data_o == $past(data_i)));  // R2
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (up_o == '0 && dn_o == '0 && bup_o == '0 && bdn_o == '0));  // R7
  AST_NO_UP_DN_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o & dn_o) == '0);  // R7
  AST_BOOST_NEEDS_CORR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bup_o & ~up_o) | (bdn_o & ~dn_o)) == '0);  // R6

  for (genvar k = 1; k < LANES; k++) begin : g_chk
    AST_LATE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && data_i[k] != data_i[k-1] && edge_i[k] == data_i[k]) |=> up_o[k]);  // R3
    AST_EARLY_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && data_i[k] != data_i[k-1] && edge_i[k] == data_i[k-1]) |=> dn_o[k]);  // R4
    AST_NO_TRANS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && data_i[k] == data_i[k-1]) |=> !(up_o[k] || dn_o[k]));  // R5
    AST_QUAD_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && quad_i[k] == data_i[k]) |=> !(bup_o[k] || bdn_o[k]));  // R6
  end
endmodule

bind qbb_phase_det qbb_phase_det_chk #(.LANES(LANES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .edge_i  (edge_i),
  .quad_i  (quad_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .up_o    (up_o),
  .dn_o    (dn_o),
  .bup_o   (bup_o),
  .bdn_o   (bdn_o)
);

// File: tb/qbb_phase_det_tb.sv
`timescale 1ns/1ps
module qbb_phase_det_tb_top;
  localparam int LANES = 4;
  localparam int N_RAND = 3000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [LANES-1:0] data_i = '0, edge_i = '0, quad_i = '0;
  logic             valid_o;
  logic [LANES-1:0] data_o, up_o, dn_o, bup_o, bdn_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic             m_prev = 1'b0;
  logic             m_hp = 1'b0;
  logic [LANES-1:0] m_data = '0;

  always #5 clk = ~clk;

  qbb_phase_det #(.LANES(LANES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .edge_i(edge_i), .quad_i(quad_i),
    .valid_o(valid_o), .data_o(data_o), .up_o(up_o), .dn_o(dn_o),
    .bup_o(bup_o), .bdn_o(bdn_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one word: drive at negedge, check at the following negedge
  task automatic step(input logic v, input logic [LANES-1:0] d,
                      input logic [LANES-1:0] e, input logic [LANES-1:0] q);
    logic [LANES-1:0] eu, ed, ebu, ebd, edata, notr;
    logic pb;
    eu = '0; ed = '0; ebu = '0; ebd = '0; notr = '0;
    edata = v ? d : m_data;
    if (v) begin
      for (int k = 0; k < LANES; k++) begin
        pb = (k == 0) ? m_prev : d[k-1];
        if (k == 0 && !m_hp) continue;
        if (pb == d[k]) begin
          notr[k] = 1'b1;
        end else begin
          eu[k]  = (e[k] == d[k]);
          ed[k]  = (e[k] == pb);
          ebu[k] = eu[k] & (q[k] != d[k]);
          ebd[k] = ed[k] & (q[k] != d[k]);
        end
      end
    end
    valid_i = v; data_i = d; edge_i = e; quad_i = q;
    @(negedge clk);
    check(v ? "R2 valid" : "R7 valid idle", 32'(valid_o), 32'(v));
    check(v ? "R2 data" : "R9 data hold", 32'(data_o), 32'(edata));
    check("R3 up lanes", 32'(up_o >> 1), 32'(eu >> 1));
    check("R4 dn lanes", 32'(dn_o >> 1), 32'(ed >> 1));
    check("R8 lane0 up/dn", 32'({up_o[0], dn_o[0]}), 32'({eu[0], ed[0]}));
    check("R6 boost up", 32'(bup_o), 32'(ebu));
    check("R6 boost dn", 32'(bdn_o), 32'(ebd));
    check("R5 no transition quiet", 32'((up_o | dn_o | bup_o | bdn_o) & notr), 32'd0);
    check("R7 up/dn overlap", 32'(up_o & dn_o), 32'd0);
    if (v) begin
      m_prev = d[LANES-1];
      m_hp = 1'b1;
      m_data = d;
    end
  endtask

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    check("R1 reset outs", 32'({valid_o, data_o, up_o, dn_o, bup_o, bdn_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'({valid_o, data_o, up_o, dn_o, bup_o, bdn_o}), 32'd0);
    // R8: first word, lane 0 has no predecessor
    step(1'b1, 4'b0101, 4'b0101, 4'b0101);
    // R5: flat word, lane 0 prev = 0
    step(1'b1, 4'b0000, 4'b1111, 4'b1111);
    // R6: jitter word, quad inverts data; both directions
    step(1'b1, 4'b1010, 4'b1100, 4'b0101);
    // R9: idle gap keeps data and stored previous bit
    step(1'b0, 4'b0110, 4'b1001, 4'b1111);
    step(1'b0, 4'b1111, 4'b0000, 4'b0000);
    // R8: lane 0 uses bit 3 of word 1010 across the gap
    step(1'b1, 4'b0001, 4'b0000, 4'b0000);
    step(1'b1, 4'b1110, 4'b0001, 4'b1111);
    for (int i = 0; i < N_RAND; i++) begin
      step(($urandom % 4) != 0, LANES'($urandom), LANES'($urandom), LANES'($urandom));
    end
    // async reset mid-stream: R1 and R8 restart
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 32'({valid_o, data_o, up_o, dn_o, bup_o, bdn_o}), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_hp = 1'b0; m_prev = 1'b0; m_data = '0;
    step(1'b1, 4'b1011, 4'b0000, 4'b0000);
    step(1'b1, 4'b0100, 4'b0100, 4'b1011);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule